// File: doc/BRIEF.md
# Instrument Status Summary Register Set

This block holds the status registers of a remotely controlled instrument and folds them into one status byte. It has three groups. The fault group is 12 bits wide and the mode group is 8 bits wide. Each of these two groups has a live condition view, a host-writable enable mask and a sticky event register. The event register captures only those conditions whose enable bit is set. The third group is an 8-bit standard event register. It latches one-cycle event pulses and power-on, and it has its own enable mask, which acts only on the summary. The status byte is computed combinationally from the enabled events of all three groups and from an error-queue-not-empty flag.

The host reaches every register through a simple port. Register data appears combinationally on `acc_rdata` while `acc_rd` is high, and a read of an event register clears it at the next clock edge. Two strobes act on all groups at once. `clr_stb` wipes every event register. `preset_stb` loads the fault and mode enables with their default masks. A small two-state sequencer (`ST_PWRON` then `ST_RUN`) raises the power-on event exactly once after reset. Its only transition is `ST_PWRON -> ST_RUN`, taken on the first clock edge after reset is released.

Register addresses on `acc_addr` are as follows:

| Address | Register | Access |
|---|---|---|
| 0 | Fault condition | read-only |
| 1 | Fault enable | read/write |
| 2 | Fault event | read, clears on read |
| 3 | Mode condition | read-only |
| 4 | Mode enable | read/write |
| 5 | Mode event | read, clears on read |
| 6 | Standard event | read, clears on read |
| 7 | Standard enable | read/write |
| 8 | Status byte | read-only |
| 9 to 15 | Unused | read as 0 |

Top module: `status_summary_top`

## Requirements
- R1: A condition register at address 0 (fault) or 3 (mode) shows its input in the same cycle, masked to its valid bits. A host write to either address changes nothing.
- R2: A fault or mode event bit is set at a clock edge only when its condition and its enable bit are both 1. It then stays set after the condition clears.
- R3: A read of address 2, 5 or 6 clears that event register at the following edge. An event being set at that same edge survives the clear.
- R4: The enable registers at addresses 1, 4 and 7 reset to 0 and read back what was written. Writing them leaves the condition registers unchanged.
- R5: The fault group uses all 12 bits, and every bit latches independently (bit 0 summary-in through bit 11 comm error). The mode group uses bits 0, 1, 2, 4, 5 and 7 (mask 0xB7). All other mode bits read 0.
- R6: The standard event register latches `std_evt_in` bits 0, 2, 3, 4 and 5 (mask 0x3D) whatever its enable holds. Bit 7 (power-on) is set once, at the first edge after reset.
- R7: The status byte (address 8 and `status_byte`) is built as follows. Bit 2 is the error-queue flag. Bit 3 is any enabled fault event. Bit 5 is any enabled standard event. Bit 7 is any enabled mode event. Bit 6 is the OR of bits 2, 3, 5 and 7. All other bits are 0.
- R8: Reading the status byte leaves it unchanged. It drops only when the events beneath it are read or cleared.
- R9: `clr_stb` zeroes all three event registers and leaves every enable register unchanged.
- R10: `preset_stb` loads the mode enable with 0x84 and the fault enable with 0xFFF, and takes priority over a write in the same cycle.
- R11: While `single_unit` is 1, bit 0 of the fault enable reads 0 and has no effect, so writing 0xFFF reads back 0xFFE. While `single_unit` is 0, bit 0 behaves as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_unit | input | 1 | 1 = standalone unit, fault bit 0 masked |
| ques_cond_in | input | 12 | Live fault conditions |
| oper_cond_in | input | 8 | Live mode conditions |
| std_evt_in | input | 8 | One-cycle standard event pulses |
| errq_nonempty | input | 1 | Error queue holds at least one entry |
| acc_wr | input | 1 | Register write strobe |
| acc_rd | input | 1 | Register read strobe |
| acc_addr | input | 4 | Register address |
| acc_wdata | input | 16 | Write data |
| clr_stb | input | 1 | Clear all event registers |
| preset_stb | input | 1 | Load default enable masks |
| acc_rdata | output | 16 | Read data, valid while acc_rd is high |
| status_byte | output | 8 | Live status summary |

## Verification
The bench targets several corner cases, and each has a distinct failure mode.
- A condition that was present before its enable was written must not latch until the enable takes effect. A design that ignores the enable would report a spurious event.
- An event set in the same cycle as a read must survive that read. A design that gives the read-clear priority would silently lose the fault.
- Reading the status byte must not disturb it. A design that treats it as an event register would drop bit 3 after the first read.
- The fault enable must read back 0xFFE in standalone mode and 0xFFF otherwise.
- The power-on bit must appear exactly once.
- The mode register must hide its unused bits, even when all eight inputs are driven high.

// File: rtl/status_pkg.sv
package status_pkg;
    localparam int QW = 12;
    localparam int OW = 8;
    localparam int SW = 8;
    localparam int AW = 4;
    localparam int DW = 16;

    localparam logic [OW-1:0] OPER_VALID  = 8'hB7;
    localparam logic [OW-1:0] OPER_PRESET = 8'h84;
    localparam logic [QW-1:0] QUES_VALID  = 12'hFFF;
    localparam logic [QW-1:0] QUES_PRESET = 12'hFFF;
    localparam logic [SW-1:0] STD_IN_MASK = 8'h3D;
    localparam int            PON_BIT     = 7;

    typedef enum logic [AW-1:0] {
        A_QCOND = 4'd0,
        A_QEN   = 4'd1,
        A_QEVT  = 4'd2,
        A_OCOND = 4'd3,
        A_OEN   = 4'd4,
        A_OEVT  = 4'd5,
        A_SEVT  = 4'd6,
        A_SEN   = 4'd7,
        A_STB   = 4'd8
    } reg_addr_e;

    typedef enum logic [0:0] {
        ST_PWRON = 1'b0,
        ST_RUN   = 1'b1
    } pwr_state_e;
endpackage

// File: rtl/status_pwr_seq.sv
module status_pwr_seq
    import status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic pon_set
);
    pwr_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWRON;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pon_set = 1'b0;
        unique case (state_q)
            ST_PWRON: begin
                pon_set = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                pon_set = 1'b0;
                state_d = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/status_cond_group.sv
module status_cond_group #(
    parameter int             W      = 8,
    parameter logic [W-1:0]   VALID  = '1,
    parameter logic [W-1:0]   PRESET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cond_in,
    input  logic [W-1:0] en_keep,
    input  logic         en_wr,
    input  logic [W-1:0] en_wdata,
    input  logic         preset,
    input  logic         clr,
    input  logic         evt_rd,
    output logic [W-1:0] cond_q,
    output logic [W-1:0] en_eff,
    output logic [W-1:0] evt_q
);
    logic [W-1:0] en_q;
    logic [W-1:0] evt_d;
    logic [W-1:0] set_v;

    assign cond_q = cond_in & VALID;
    assign en_eff = en_q & en_keep;
    assign set_v  = cond_q & en_eff;

    always_comb begin
        evt_d = (clr || evt_rd) ? '0 : evt_q;
        evt_d = evt_d | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            evt_q <= '0;
        end else begin
            if (preset)     en_q <= PRESET;
            else if (en_wr) en_q <= en_wdata;
            evt_q <= evt_d;
        end
    end
endmodule

// File: rtl/status_std_event.sv
module status_std_event
    import status_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [SW-1:0] evt_in,
    input  logic          pon_set,
    input  logic          en_wr,
    input  logic [SW-1:0] en_wdata,
    input  logic          clr,
    input  logic          evt_rd,
    output logic [SW-1:0] en_q,
    output logic [SW-1:0] evt_q
);
    logic [SW-1:0] set_v;
    logic [SW-1:0] evt_d;

    always_comb begin
        set_v          = evt_in & STD_IN_MASK;
        set_v[PON_BIT] = pon_set;
        evt_d          = ((clr || evt_rd) ? '0 : evt_q) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            evt_q <= '0;
        end else begin
            if (en_wr) en_q <= en_wdata;
            evt_q <= evt_d;
        end
    end
endmodule

// File: rtl/status_summary_top.sv
module status_summary_top
    import status_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          single_unit,
    input  logic [QW-1:0] ques_cond_in,
    input  logic [OW-1:0] oper_cond_in,
    input  logic [SW-1:0] std_evt_in,
    input  logic          errq_nonempty,
    input  logic          acc_wr,
    input  logic          acc_rd,
    input  logic [AW-1:0] acc_addr,
    input  logic [DW-1:0] acc_wdata,
    input  logic          clr_stb,
    input  logic          preset_stb,
    output logic [DW-1:0] acc_rdata,
    output logic [7:0]    status_byte
);
    logic [QW-1:0] ques_cond, ques_en_eff, ques_evt, ques_keep;
    logic [OW-1:0] oper_cond, oper_en_eff, oper_evt;
    logic [SW-1:0] std_en, std_evt;
    logic          pon_set;

    assign ques_keep = {{(QW-1){1'b1}}, ~single_unit};

    status_pwr_seq u_pwr (
        .clk     (clk),
        .rst_n   (rst_n),
        .pon_set (pon_set)
    );

    status_cond_group #(.W(QW), .VALID(QUES_VALID), .PRESET(QUES_PRESET)) u_ques (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_in  (ques_cond_in),
        .en_keep  (ques_keep),
        .en_wr    (acc_wr && acc_addr == A_QEN),
        .en_wdata (acc_wdata[QW-1:0]),
        .preset   (preset_stb),
        .clr      (clr_stb),
        .evt_rd   (acc_rd && acc_addr == A_QEVT),
        .cond_q   (ques_cond),
        .en_eff   (ques_en_eff),
        .evt_q    (ques_evt)
    );

    status_cond_group #(.W(OW), .VALID(OPER_VALID), .PRESET(OPER_PRESET)) u_oper (
        .clk      (clk),
        .rst_n    (rst_n),
        .cond_in  (oper_cond_in),
        .en_keep  ({OW{1'b1}}),
        .en_wr    (acc_wr && acc_addr == A_OEN),
        .en_wdata (acc_wdata[OW-1:0]),
        .preset   (preset_stb),
        .clr      (clr_stb),
        .evt_rd   (acc_rd && acc_addr == A_OEVT),
        .cond_q   (oper_cond),
        .en_eff   (oper_en_eff),
        .evt_q    (oper_evt)
    );

    status_std_event u_std (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_in   (std_evt_in),
        .pon_set  (pon_set),
        .en_wr    (acc_wr && acc_addr == A_SEN),
        .en_wdata (acc_wdata[SW-1:0]),
        .clr      (clr_stb),
        .evt_rd   (acc_rd && acc_addr == A_SEVT),
        .en_q     (std_en),
        .evt_q    (std_evt)
    );

    always_comb begin
        status_byte    = '0;
        status_byte[2] = errq_nonempty;
        status_byte[3] = |(ques_evt & ques_en_eff);
        status_byte[5] = |(std_evt & std_en);
        status_byte[7] = |(oper_evt & oper_en_eff);
        status_byte[6] = status_byte[2] | status_byte[3] | status_byte[5] | status_byte[7];
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_rd) begin
            case (acc_addr)
                A_QCOND: acc_rdata[QW-1:0] = ques_cond;
                A_QEN:   acc_rdata[QW-1:0] = ques_en_eff;
                A_QEVT:  acc_rdata[QW-1:0] = ques_evt;
                A_OCOND: acc_rdata[OW-1:0] = oper_cond;
                A_OEN:   acc_rdata[OW-1:0] = oper_en_eff;
                A_OEVT:  acc_rdata[OW-1:0] = oper_evt;
                A_SEVT:  acc_rdata[SW-1:0] = std_evt;
                A_SEN:   acc_rdata[SW-1:0] = std_en;
                A_STB:   acc_rdata[7:0]    = status_byte;
                default: acc_rdata         = '0;
            endcase
        end
    end
endmodule

// File: rtl/status_summary_chk.sv
module status_summary_chk
    import status_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          single_unit,
    input logic          errq_nonempty,
    input logic          acc_rd,
    input logic [AW-1:0] acc_addr,
    input logic [DW-1:0] acc_rdata,
    input logic          clr_stb,
    input logic          preset_stb,
    input logic [SW-1:0] std_evt_in,
    input logic [7:0]    status_byte,
    input logic [QW-1:0] ques_cond,
    input logic [QW-1:0] ques_en_eff,
    input logic [QW-1:0] ques_evt,
    input logic [OW-1:0] oper_cond,
    input logic [OW-1:0] oper_en_eff,
    input logic [OW-1:0] oper_evt,
    input logic [SW-1:0] std_evt
);
    logic ques_set, oper_set, std_set;
    assign ques_set = |(ques_cond & ques_en_eff);
    assign oper_set = |(oper_cond & oper_en_eff);
    assign std_set  = |(std_evt_in & STD_IN_MASK);

    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ques_set |=> (ques_evt != '0));

    p_rdclr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && acc_addr == A_QEVT && !ques_set) |=> (ques_evt == '0));

    p_errq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        errq_nonempty |-> (status_byte[2] && status_byte[6]));

    p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !ques_set && !oper_set && !std_set) |=>
            (ques_evt == '0 && oper_evt == '0 && std_evt[5:0] == '0));

    p_preset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        preset_stb |=> (oper_en_eff == OPER_PRESET && ques_en_eff[QW-1:1] == QUES_PRESET[QW-1:1]));

    p_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (single_unit && acc_rd && acc_addr == A_QEN) |-> (acc_rdata[0] == 1'b0));
endmodule

bind status_summary_top status_summary_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .single_unit   (single_unit),
    .errq_nonempty (errq_nonempty),
    .acc_rd        (acc_rd),
    .acc_addr      (acc_addr),
    .acc_rdata     (acc_rdata),
    .clr_stb       (clr_stb),
    .preset_stb    (preset_stb),
    .std_evt_in    (std_evt_in),
    .status_byte   (status_byte),
    .ques_cond     (ques_cond),
    .ques_en_eff   (ques_en_eff),
    .ques_evt      (ques_evt),
    .oper_cond     (oper_cond),
    .oper_en_eff   (oper_en_eff),
    .oper_evt      (oper_evt),
    .std_evt       (std_evt)
);

// File: tb/test_status_summary_top.sv
module test_status_summary_top;
    import status_pkg::*;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          single_unit = 1'b1;
    logic [QW-1:0] ques_cond_in = '0;
    logic [OW-1:0] oper_cond_in = '0;
    logic [SW-1:0] std_evt_in = '0;
    logic          errq_nonempty = 1'b0;
    logic          acc_wr = 1'b0;
    logic          acc_rd = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic          clr_stb = 1'b0;
    logic          preset_stb = 1'b0;
    logic [DW-1:0] acc_rdata;
    logic [7:0]    status_byte;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    status_summary_top i_status_summary_top (
        .clk, .rst_n, .single_unit, .ques_cond_in, .oper_cond_in, .std_evt_in,
        .errq_nonempty, .acc_wr, .acc_rd, .acc_addr, .acc_wdata, .clr_stb,
        .preset_stb, .acc_rdata, .status_byte
    );

    // ctl: 0 none, 1 clear strobe, 2 preset strobe
    typedef struct packed {
        logic [1:0]  ctl;
        logic        wr;
        logic        rd;
        logic [3:0]  addr;
        logic [15:0] wdata;
        logic [11:0] qc;
        logic [7:0]  oc;
        logic [7:0]  se;
        logic        errq;
        logic        chk;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VEC [NV] = '{
        '{2'd0,1'b0,1'b1,4'd6,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0080,8'd6},  // R6 power-on
        '{2'd0,1'b0,1'b1,4'd6,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd3},  // R3 cleared
        '{2'd0,1'b0,1'b1,4'd0,16'h0,12'h006,8'h00,8'h00,1'b0,1'b1,16'h0006,8'd1},  // R1 live
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h006,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd2},  // R2 not enabled
        '{2'd0,1'b1,1'b0,4'd1,16'h4,12'h006,8'h00,8'h00,1'b0,1'b0,16'h0000,8'd4},
        '{2'd0,1'b0,1'b0,4'd0,16'h0,12'h006,8'h00,8'h00,1'b0,1'b0,16'h0000,8'd2},
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0048,8'd7},  // R7 ques summary
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0048,8'd8},  // R8 no clear
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0004,8'd2},  // R2 held
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd8},  // R8 drops
        '{2'd0,1'b1,1'b0,4'd4,16'h1,12'h000,8'h01,8'h00,1'b0,1'b0,16'h0000,8'd4},
        '{2'd0,1'b0,1'b0,4'd0,16'h0,12'h000,8'h01,8'h00,1'b0,1'b0,16'h0000,8'd2},
        '{2'd0,1'b0,1'b1,4'd3,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd1},  // R1 mode live
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h00C0,8'd7},  // R7 mode summary
        '{2'd0,1'b0,1'b1,4'd5,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0001,8'd2},  // R2 mode event
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd3},  // R3
        '{2'd2,1'b0,1'b0,4'd0,16'h0,12'h000,8'h00,8'h00,1'b0,1'b0,16'h0000,8'd10},
        '{2'd0,1'b0,1'b1,4'd4,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0084,8'd10}, // R10
        '{2'd0,1'b0,1'b1,4'd1,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0FFE,8'd11}, // R11
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b1,1'b1,16'h0044,8'd7},  // R7 errq
        '{2'd0,1'b1,1'b0,4'd7,16'h20,12'h000,8'h00,8'h20,1'b0,1'b0,16'h0000,8'd6},
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0060,8'd7},  // R7 std summary
        '{2'd1,1'b0,1'b0,4'd0,16'h0,12'h000,8'h00,8'h00,1'b0,1'b0,16'h0000,8'd9},
        '{2'd0,1'b0,1'b1,4'd8,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd9},  // R9 cleared
        '{2'd0,1'b0,1'b1,4'd7,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0020,8'd9},  // R9 enable kept
        '{2'd0,1'b0,1'b1,4'd4,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0084,8'd9},  // R9 enable kept
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h010,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd3},  // R3 read+set
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0010,8'd3},  // R3 survived
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd3},  // R3
        '{2'd0,1'b1,1'b0,4'd0,16'hFFF,12'h000,8'h00,8'h00,1'b0,1'b0,16'h0000,8'd1},
        '{2'd0,1'b0,1'b1,4'd0,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0000,8'd1},  // R1 write ignored
        '{2'd0,1'b0,1'b1,4'd3,16'h0,12'h000,8'hFF,8'h00,1'b0,1'b1,16'h00B7,8'd5},  // R5 mode mask
        '{2'd0,1'b0,1'b1,4'd5,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0084,8'd2},  // R2 enabled only
        '{2'd0,1'b0,1'b0,4'd0,16'h0,12'h000,8'h00,8'hFF,1'b0,1'b0,16'h0000,8'd6},
        '{2'd0,1'b0,1'b1,4'd6,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h003D,8'd6},  // R6 mask, no PON
        '{2'd0,1'b0,1'b1,4'd0,16'h0,12'hFFF,8'h00,8'h00,1'b0,1'b1,16'h0FFF,8'd5},  // R5 all bits
        '{2'd0,1'b0,1'b1,4'd2,16'h0,12'h000,8'h00,8'h00,1'b0,1'b1,16'h0FFE,8'd11}  // R11 bit 0 masked
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        clr_stb       = (v.ctl == 2'd1);
        preset_stb    = (v.ctl == 2'd2);
        acc_wr        = v.wr;
        acc_rd        = v.rd;
        acc_addr      = v.addr;
        acc_wdata     = v.wdata;
        ques_cond_in  = v.qc;
        oper_cond_in  = v.oc;
        std_evt_in    = v.se;
        errq_nonempty = v.errq;
        #5;
        if (v.chk) check($sformatf("R%0d (vector)", v.req), acc_rdata, v.exp);
    endtask

    function automatic vec_t mk(input logic wr, input logic rd, input logic [3:0] a,
                                input logic [15:0] wd, input logic [11:0] qc);
        vec_t v = '0;
        v.wr = wr; v.rd = rd; v.addr = a; v.wdata = wd; v.qc = qc;
        return v;
    endfunction

    initial begin
        #10000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: enables zero (R4), status byte clear (R7)
        repeat (3) @(negedge clk);
        acc_rd = 1'b1; acc_addr = A_QEN;
        #1 check("R4 reset fault enable", acc_rdata, 16'h0);
        acc_addr = A_SEN;
        #1 check("R4 reset std enable", acc_rdata, 16'h0);
        check("R7 reset status byte", {8'h0, status_byte}, 16'h0);
        acc_rd = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) drive(VEC[i]);

        // R11: multi-unit mode keeps bit 0
        single_unit = 1'b0;
        drive(mk(1'b1, 1'b0, A_QEN, 16'h0FFF, 12'h000));
        drive(mk(1'b0, 1'b1, A_QEN, 16'h0, 12'h000));
        check("R11 multi-unit readback", acc_rdata, 16'h0FFF);
        drive(mk(1'b0, 1'b0, A_QCOND, 16'h0, 12'h001));
        drive(mk(1'b0, 1'b1, A_QEVT, 16'h0, 12'h000));
        check("R11 bit 0 latches", acc_rdata, 16'h0001);
        check("R7 live byte bit 3", {8'h0, status_byte}, 16'h0048);

        // R10: preset beats a simultaneous write
        begin
            vec_t v = mk(1'b1, 1'b0, A_OEN, 16'h0003, 12'h000);
            v.ctl = 2'd2;
            drive(v);
        end
        drive(mk(1'b0, 1'b1, A_OEN, 16'h0, 12'h000));
        check("R10 preset priority", acc_rdata, 16'h0084);

        // R4: enable write does not change condition view
        drive(mk(1'b1, 1'b0, A_QEN, 16'h0000, 12'h0A5));
        drive(mk(1'b0, 1'b1, A_QCOND, 16'h0, 12'h0A5));
        check("R4 condition unchanged", acc_rdata, 16'h00A5);

        drive(mk(1'b0, 1'b0, A_QCOND, 16'h0, 12'h000));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule